// File: doc/BRIEF.md
# Multi-stream USB result packetizer

This block takes radar processing results from three producers (a 32-bit range word, a 32-bit Doppler word and an 8-bit detection byte) and turns them into a byte stream for a USB FIFO. The output uses a valid/ready handshake. A 3-bit stream-enable register chooses which producers take part. Only a range event can open a packet.

Doppler and detection results may arrive at any time. Each one is held in its own slot with a sticky pending flag. When a range event opens a packet, every pending slot is appended to the packet and its flag is cleared. Because a missing optional result never blocks a packet, the block cannot deadlock at start-up when the optional producers have not yet delivered anything.

The physical USB bridge, the command/read path and clock-domain crossing are outside the block. Everything runs on one clock with a synchronous active-low reset.

Top module: `usb_result_packer`

## Requirements
- R1: After reset the enable register reads 3'b001 (bit 0 range, bit 1 Doppler, bit 2 detection), out_valid is 0, overrun is 0 and no result is pending.
- R2: A packet opens only on a cycle where rng_valid is high, enable bit 0 is set and no packet is being sent. Its first byte is valid in the next cycle. Doppler or detection pulses never open a packet.
- R3: A packet is sent in this order: a header byte, the range word, the Doppler word (only if it is pending), the detection byte (only if it is pending), then the footer byte 0x5F. Multi-byte words go most significant byte first. The header is 0xA0, plus 1 when the Doppler word is included, plus 2 when the detection byte is included.
- R4: A Doppler pulse makes its result pending only while enable bit 1 is set. A detection pulse does so only while enable bit 2 is set. A pulse on a disabled stream is discarded and never appears in a packet.
- R5: A pending flag stays set until a packet opens, and that packet carries its data. The flag is cleared at that moment. A result that arrives in the same cycle a packet opens stays pending for the next packet.
- R6: A new result that arrives while its flag is already set replaces the held data. Only the latest value is sent, and only once.
- R7: With all streams enabled but no Doppler or detection result pending, a range event still produces a complete packet that holds only the header 0xA0, the range word and the footer.
- R8: The output moves to the next byte only in a cycle where out_valid and out_ready are both high. While out_ready is low, out_byte and out_valid hold their values. With out_ready held high, one byte is sent per cycle.
- R9: An rng_valid pulse that arrives while a packet is being sent is dropped. It sets overrun in the next cycle, and overrun stays high until reset.
- R10: A write through ctrl_we updates the enable register in the next cycle. Results pulsed in that same cycle are still gated by the old enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the enable register |
| ctrl_wdata | input | 3 | New enable value (bit 0 range, bit 1 Doppler, bit 2 detection) |
| ctrl_q | output | 3 | Current enable register |
| rng_valid | input | 1 | Range result strobe; opens a packet |
| rng_word | input | 32 | Range result |
| dop_valid | input | 1 | Doppler result strobe |
| dop_word | input | 32 | Doppler result |
| det_valid | input | 1 | Detection result strobe |
| det_word | input | 8 | Detection flags |
| out_byte | output | 8 | Byte toward the FIFO |
| out_valid | output | 1 | out_byte is valid |
| out_ready | input | 1 | FIFO accepts a byte |
| overrun | output | 1 | Sticky flag for a dropped range event |

## Verification
Every result is due one clock edge after the stimulus that causes it. The header appears in the cycle after an accepted range pulse. Each later byte appears in the cycle after the previous byte was accepted. The overrun flag and a new enable value also appear one cycle after their trigger, and a pending result only shows up in the next packet that opens. A behavioural model in the bench keeps a queue of the bytes still owed. It applies each cycle's inputs at the same edge the design does, and it is compared with every output on the falling edge that follows, so every result is checked in the exact cycle it is due.

// File: rtl/usb_pkt_pkg.sv
// Shared constants and types for the USB result packetizer.
// Assumes all result widths are whole bytes.
package usb_pkt_pkg;
    localparam logic [7:0] HDR_BASE = 8'hA0;
    localparam logic [7:0] FTR_BYTE = 8'h5F;

    // Stream enables; bit order is decoded by software, so it is fixed.
    typedef struct packed {
        logic det;
        logic dop;
        logic rng;
    } strm_en_t;
endpackage

// File: rtl/hold_slot.sv
// Holds the latest result of one optional stream behind a sticky pending flag.
// Assumes take is high only in the cycle a packet opens; new data wins over take.
module hold_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    input  logic         take,
    output logic         pend,
    output logic [W-1:0] held
);
    // Capture, overwrite or release the held result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            held <= '0;
        end else if (in_vld && en) begin
            pend <= 1'b1;
            held <= in_data;
        end else if (take) begin
            pend <= 1'b0;
        end
    end

    // R5
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !take |=> pend);
    // R4
    pend_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend && !(in_vld && en) |=> !pend);
endmodule

// File: rtl/frame_build.sv
// Assembles a left-justified packet image and its byte count from held results.
// Purely combinational; assumes all widths are whole bytes.
module frame_build
    import usb_pkt_pkg::*;
#(
    parameter int RNG_W = 32,
    parameter int DOP_W = 32,
    parameter int DET_W = 8,
    parameter int FRM_W = 16 + RNG_W + DOP_W + DET_W,
    parameter int CNT_W = $clog2(FRM_W / 8 + 1)
) (
    input  logic [RNG_W-1:0] rng,
    input  logic [DOP_W-1:0] dop,
    input  logic [DET_W-1:0] det,
    input  logic             has_dop,
    input  logic             has_det,
    output logic [FRM_W-1:0] frame,
    output logic [CNT_W-1:0] nbytes
);
    localparam int BASE_B = 2 + RNG_W / 8;
    localparam int DOP_B  = DOP_W / 8;
    localparam int DET_B  = DET_W / 8;

    logic [7:0] hdr;

    // Pick the section layout from the pending flags.
    always_comb begin
        hdr = HDR_BASE | {6'b0, has_det, has_dop};
        unique case ({has_det, has_dop})
            2'b00: begin
                frame  = {hdr, rng, FTR_BYTE, {(DOP_W + DET_W){1'b0}}};
                nbytes = CNT_W'(BASE_B);
            end
            2'b01: begin
                frame  = {hdr, rng, dop, FTR_BYTE, {DET_W{1'b0}}};
                nbytes = CNT_W'(BASE_B + DOP_B);
            end
            2'b10: begin
                frame  = {hdr, rng, det, FTR_BYTE, {DOP_W{1'b0}}};
                nbytes = CNT_W'(BASE_B + DET_B);
            end
            default: begin
                frame  = {hdr, rng, dop, det, FTR_BYTE};
                nbytes = CNT_W'(BASE_B + DOP_B + DET_B);
            end
        endcase
    end
endmodule

// File: rtl/byte_sender.sv
// Shifts a loaded packet out one byte per accepted handshake and flags dropped range events.
// Assumes load is only raised while not busy.
module byte_sender #(
    parameter int FRM_W = 88,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [FRM_W-1:0] frame_in,
    input  logic [CNT_W-1:0] n_in,
    input  logic             rng_evt,
    input  logic             out_ready,
    output logic [7:0]       out_byte,
    output logic             out_valid,
    output logic             busy,
    output logic             overrun
);
    logic [FRM_W-1:0] sr;
    logic [CNT_W-1:0] cnt;

    assign busy      = (cnt != '0);
    assign out_valid = busy;
    assign out_byte  = sr[FRM_W-1 -: 8];

    // Load a packet or advance on an accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (load) begin
            sr  <= frame_in;
            cnt <= n_in;
        end else if (busy && out_ready) begin
            sr  <= {sr[FRM_W-9:0], 8'h00};
            cnt <= cnt - 1'b1;
        end
    end

    // Record a range event lost to a busy sender.
    always_ff @(posedge clk) begin
        if (!rst_n)                overrun <= 1'b0;
        else if (rng_evt && busy)  overrun <= 1'b1;
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte));
    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rng_evt && busy |=> overrun);
endmodule

// File: rtl/usb_result_packer.sv
// Top of the packetizer: enable register, two pending slots, builder and sender.
// Assumes a single clock domain; a packet opens only on an enabled range event.
module usb_result_packer
    import usb_pkt_pkg::*;
#(
    parameter int RNG_W = 32,
    parameter int DOP_W = 32,
    parameter int DET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic [2:0]       ctrl_wdata,
    output logic [2:0]       ctrl_q,
    input  logic             rng_valid,
    input  logic [RNG_W-1:0] rng_word,
    input  logic             dop_valid,
    input  logic [DOP_W-1:0] dop_word,
    input  logic             det_valid,
    input  logic [DET_W-1:0] det_word,
    output logic [7:0]       out_byte,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             overrun
);
    localparam int FRM_W = 16 + RNG_W + DOP_W + DET_W;
    localparam int CNT_W = $clog2(FRM_W / 8 + 1);

    strm_en_t         en_q;
    logic             busy, start;
    logic             dop_pend, det_pend;
    logic [DOP_W-1:0] dop_held;
    logic [DET_W-1:0] det_held;
    logic [FRM_W-1:0] frame;
    logic [CNT_W-1:0] nbytes;

    assign ctrl_q = en_q;
    assign start  = rng_valid && en_q.rng && !busy;

    // Stream enable register, range only after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= 3'b001;
        else if (ctrl_we) en_q <= ctrl_wdata;
    end

    hold_slot #(.W(DOP_W)) i_dop_slot (
        .clk(clk), .rst_n(rst_n), .en(en_q.dop), .in_vld(dop_valid),
        .in_data(dop_word), .take(start), .pend(dop_pend), .held(dop_held)
    );

    hold_slot #(.W(DET_W)) i_det_slot (
        .clk(clk), .rst_n(rst_n), .en(en_q.det), .in_vld(det_valid),
        .in_data(det_word), .take(start), .pend(det_pend), .held(det_held)
    );

    frame_build #(
        .RNG_W(RNG_W), .DOP_W(DOP_W), .DET_W(DET_W), .FRM_W(FRM_W), .CNT_W(CNT_W)
    ) i_build (
        .rng(rng_word), .dop(dop_held), .det(det_held),
        .has_dop(dop_pend), .has_det(det_pend), .frame(frame), .nbytes(nbytes)
    );

    byte_sender #(.FRM_W(FRM_W), .CNT_W(CNT_W)) i_send (
        .clk(clk), .rst_n(rst_n), .load(start), .frame_in(frame), .n_in(nbytes),
        .rng_evt(rng_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_valid(out_valid), .busy(busy), .overrun(overrun)
    );

    // R2
    no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && !rng_valid |=> !out_valid);
    // R3
    header_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_byte[7:4] == 4'hA);
    // R10
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ctrl_q == $past(ctrl_wdata));
endmodule

// File: tb/test_usb_result_packer.sv
`timescale 1ns/1ps
module test_usb_result_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [2:0]  ctrl_wdata = 3'b000;
    logic [2:0]  ctrl_q;
    logic        rng_valid = 1'b0;
    logic [31:0] rng_word = '0;
    logic        dop_valid = 1'b0;
    logic [31:0] dop_word = '0;
    logic        det_valid = 1'b0;
    logic [7:0]  det_word = '0;
    logic [7:0]  out_byte;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        overrun;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    byte unsigned mq[$];
    bit          m_ovr;
    bit [2:0]    m_ctrl;
    bit          m_dp, m_cp;
    bit [31:0]   m_dd;
    bit [7:0]    m_cd;

    always #2.5 clk = ~clk;

    usb_result_packer i_usb_result_packer (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .rng_valid(rng_valid), .rng_word(rng_word),
        .dop_valid(dop_valid), .dop_word(dop_word), .det_valid(det_valid),
        .det_word(det_word), .out_byte(out_byte), .out_valid(out_valid),
        .out_ready(out_ready), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare outputs with the model, then advance the model and the clock.
    task automatic cyc(input string tag);
        bit busy, start;
        chk(ctrl_q == m_ctrl, tag, "ctrl_q", ctrl_q, m_ctrl);
        chk(out_valid == (mq.size() > 0), tag, "out_valid", out_valid, mq.size() > 0);
        if (mq.size() > 0)
            chk(out_byte == mq[0], tag, "out_byte", out_byte, mq[0]);
        chk(overrun == m_ovr, tag, "overrun", overrun, m_ovr);
        busy  = mq.size() > 0;
        start = !busy && rng_valid && m_ctrl[0];
        if (busy && out_ready) void'(mq.pop_front());
        if (busy && rng_valid) m_ovr = 1'b1;
        if (start) begin
            mq.push_back(8'hA0 + (m_dp ? 1 : 0) + (m_cp ? 2 : 0));
            for (int i = 3; i >= 0; i--) mq.push_back(rng_word[i*8 +: 8]);
            if (m_dp) for (int i = 3; i >= 0; i--) mq.push_back(m_dd[i*8 +: 8]);
            if (m_cp) mq.push_back(m_cd);
            mq.push_back(8'h5F);
            m_dp = 1'b0;
            m_cp = 1'b0;
        end
        if (dop_valid && m_ctrl[1]) begin m_dp = 1'b1; m_dd = dop_word; end
        if (det_valid && m_ctrl[2]) begin m_cp = 1'b1; m_cd = det_word; end
        if (ctrl_we) m_ctrl = ctrl_wdata;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic clear_in();
        ctrl_we = 1'b0; rng_valid = 1'b0; dop_valid = 1'b0; det_valid = 1'b0;
    endtask

    task automatic finish_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk(ctrl_q == 3'b001, "R1", "ctrl_q", ctrl_q, 1);
        chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        chk(overrun == 1'b0, "R1", "overrun", overrun, 0);
        rst_n = 1'b1;
        m_ctrl = 3'b001; m_ovr = 1'b0; m_dp = 1'b0; m_cp = 1'b0;

        // R4: optional results discarded while disabled; R2: they open nothing
        dop_valid = 1'b1; dop_word = 32'hDEAD0001; det_valid = 1'b1; det_word = 8'h11;
        cyc("R4");
        clear_in();
        idle(4, "R2");
        rng_valid = 1'b1; rng_word = 32'h01020304;
        cyc("R2");
        clear_in();
        idle(8, "R4");

        // R10: enable everything; same-cycle doppler gated by old enables
        ctrl_we = 1'b1; ctrl_wdata = 3'b111; dop_valid = 1'b1; dop_word = 32'hBAD00BAD;
        cyc("R10");
        clear_in();
        idle(2, "R10");

        // R7: range with nothing pending still completes
        rng_valid = 1'b1; rng_word = 32'hA1B2C3D4;
        cyc("R7");
        clear_in();
        idle(8, "R7");

        // R3: full packet with both optional sections
        dop_valid = 1'b1; dop_word = 32'h55667788;
        cyc("R3");
        clear_in();
        det_valid = 1'b1; det_word = 8'h3C;
        cyc("R3");
        clear_in();
        idle(3, "R3");
        rng_valid = 1'b1; rng_word = 32'h11223344;
        cyc("R3");
        clear_in();
        idle(13, "R3");

        // R6: overwrite while pending
        dop_valid = 1'b1; dop_word = 32'h0000AAAA;
        cyc("R6");
        dop_word = 32'h0000BBBB;
        cyc("R6");
        clear_in();
        rng_valid = 1'b1; rng_word = 32'hCAFEF00D;
        cyc("R6");
        clear_in();
        idle(12, "R6");

        // R5: result arriving in the opening cycle waits for the next packet
        det_valid = 1'b1; det_word = 8'h77;
        cyc("R5");
        clear_in();
        rng_valid = 1'b1; rng_word = 32'h0BADCAFE; dop_valid = 1'b1; dop_word = 32'h12345678;
        cyc("R5");
        clear_in();
        idle(9, "R5");
        rng_valid = 1'b1; rng_word = 32'h87654321;
        cyc("R5");
        clear_in();
        idle(12, "R5");

        // R8: back-pressure pattern during a packet
        dop_valid = 1'b1; dop_word = 32'hF0E1D2C3; det_valid = 1'b1; det_word = 8'h9A;
        cyc("R8");
        clear_in();
        rng_valid = 1'b1; rng_word = 32'h13579BDF;
        cyc("R8");
        clear_in();
        for (int i = 0; i < 30; i++) begin
            out_ready = (i % 3) != 0;
            cyc("R8");
        end
        out_ready = 1'b1;
        idle(6, "R8");

        // R9: range during a packet is dropped and overrun sticks
        rng_valid = 1'b1; rng_word = 32'h2468ACE0;
        cyc("R9");
        rng_word = 32'hFFFF0000;
        cyc("R9");
        clear_in();
        idle(10, "R9");
        chk(overrun == 1'b1, "R9", "overrun sticky", overrun, 1);

        // R2: range ignored when range stream disabled
        ctrl_we = 1'b1; ctrl_wdata = 3'b110;
        cyc("R2");
        clear_in();
        rng_valid = 1'b1;
        cyc("R2");
        clear_in();
        idle(4, "R2");

        finish_up();
    end
endmodule